// File: doc/BRIEF.md
# Burst-Length SPI Master

This block is a register-programmed SPI master that runs one burst of any length from 1 to 4096 bits. Software fills a transmit queue with 32-bit words, chooses one of four chip selects and the bit count, and then starts the exchange with a single control write. The block produces the serial clock, the outgoing data line and the four select lines. It collects the incoming data line into a receive queue that software drains through the same register port.

The bit count does not have to be a whole number of words. When it is not a multiple of 32, the first word carries only the leftover bits, right-aligned, and those bits go out first. Every later word carries 32 bits. Bits go out most significant first. Clock phase, clock polarity, select polarity and the clock rest level are stored separately for each chip select. The settings of the chosen channel are captured when a burst starts. Two sticky status flags, burst done and receive overflow, are cleared by writing a 1 to their positions.

Top module: `spi_burst_master`

## Requirements
- R1: After reset the control, setup and status registers read 0, every select line is high (inactive for select polarity 0) and the serial clock is 0.
- R2: A burst starts only when one write to the control word (address 0) sets bit 0 (enable), bit 1 (master) and bit 2 (go) together while no burst runs. A go write that lacks enable or master produces no clock edge and leaves status and the go bit at 0.
- R3: A burst carries exactly N+1 bits, where N is control bits 31:20, so the slave sees exactly N+1 sampling edges.
- R4: Transmit words are written at address 3. The first word sends its low ((N+1) mod 32) bits, or all 32 when that value is 0, most significant of them first. Later words send all 32 bits, bit 31 first.
- R5: Received bits are packed the same way: the first receive word holds the leftover bits right-aligned with zeros above, and later words are full. A read of address 4 returns the oldest receive word and removes it. A read of an empty queue returns 0.
- R6: The setup word (address 1) holds, for chip select c, phase at bit c, polarity at bit 4+c, select polarity at bit 12+c and clock rest level at bit 20+c. With phase 0 the slave samples on the first clock edge of each bit. With phase 1 it samples on the second edge. During a burst the clock sits at the polarity level between pulses. Outside a burst it sits at the rest level of the channel held in control bits 19:18.
- R7: Control bits 19:18 choose the select. During the whole burst that line sits at its select-polarity level and every other line sits at the opposite of its own polarity bit. After the burst all lines return to their inactive levels.
- R8: At the end of a burst, status bit 7 (done) becomes 1 and control bit 2 reads back 0. Writing 1 to status bit 7 clears the done flag.
- R9: The receive queue holds 8 words. A word completed while the queue is full is dropped and sets status bit 6, and the 8 stored words are kept. Writing 1 to status bit 6 clears the flag.
- R10: If the transmit queue is empty when a word is needed, that word is sent as all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive queue at address 4) |
| reg_addr | input | 3 | Word address: 0 control, 1 setup, 2 status, 3 transmit, 4 receive |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of the strobe |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the slave |
| miso_i | input | 1 | Serial data from the slave |
| ss_o | output | 4 | Chip-select lines |

## Verification
Most internal faults in this block surface at the pins within one bit period. A wrong bit counter gives an extra or missing sampling edge at the end of the burst. A misaligned first-word shift corrupts the leading bits on the data line at once. A wrong receive packing shows up in the first word read back after the done flag rises. Select and clock-level faults show as wrong pin levels that can be sampled between transfers. Overflow and flag-clear faults show in the next status read.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned NUM_CS = 4;
    localparam int unsigned CS_W   = $clog2(NUM_CS);
    localparam int unsigned LEN_W  = 12;

    localparam logic [2:0] ADDR_CTRL = 3'd0;
    localparam logic [2:0] ADDR_SETUP = 3'd1;
    localparam logic [2:0] ADDR_STAT = 3'd2;
    localparam logic [2:0] ADDR_TXQ  = 3'd3;
    localparam logic [2:0] ADDR_RXQ  = 3'd4;

    localparam int unsigned CTL_ENABLE = 0;
    localparam int unsigned CTL_MASTER = 1;
    localparam int unsigned CTL_GO     = 2;
    localparam int unsigned CTL_SEL_LO = 18;
    localparam int unsigned CTL_LEN_LO = 20;

    localparam int unsigned SET_PHA = 0;
    localparam int unsigned SET_POL = 4;
    localparam int unsigned SET_SSP = 12;
    localparam int unsigned SET_RST = 20;

    localparam int unsigned ST_OVF  = 6;
    localparam int unsigned ST_DONE = 7;

    typedef struct packed {
        logic              enable;
        logic              master;
        logic              go;
        logic [CS_W-1:0]   sel;
        logic [LEN_W-1:0]  len_m1;
        logic [NUM_CS-1:0] pha;
        logic [NUM_CS-1:0] pol;
        logic [NUM_CS-1:0] ssp;
        logic [NUM_CS-1:0] rst_lvl;
        logic              done_flag;
        logic              ovf_flag;
    } regs_t;
endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
    parameter int unsigned W     = 32,
    parameter int unsigned DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic do_push, do_pop;

    assign empty   = (st_q.cnt == '0);
    assign full    = (st_q.cnt == CW'(DEPTH));
    assign head    = st_q.mem[st_q.rp];
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_comb begin
        st_d = st_q;
        if (do_push) begin
            st_d.mem[st_q.wp] = push_data;
            st_d.wp = (st_q.wp == LAST) ? '0 : st_q.wp + 1'b1;
        end
        if (do_pop) begin
            st_d.rp = (st_q.rp == LAST) ? '0 : st_q.rp + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
    parameter int unsigned W        = 32,
    parameter int unsigned LEN_W    = 12,
    parameter int unsigned CS_W     = 2,
    parameter int unsigned HALF_DIV = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic [CS_W-1:0]  chan_i,
    input  logic             pol_i,
    input  logic             pha_i,
    input  logic             rest_i,
    input  logic [W-1:0]     tx_word_i,
    output logic             tx_pop_o,
    output logic             rx_push_o,
    output logic [W-1:0]     rx_word_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [CS_W-1:0]  chan_o,
    output logic             sclk_o,
    output logic             mosi_o,
    input  logic             miso_i
);
    localparam int unsigned DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam int unsigned BIT_W = LEN_W + 1;
    localparam int unsigned SH_W  = $clog2(W);
    localparam int unsigned WB_W  = SH_W + 1;
    localparam logic [DIV_W-1:0] DIV_END = DIV_W'(HALF_DIV - 1);

    typedef struct packed {
        logic             busy;
        logic             half;
        logic [DIV_W-1:0] div;
        logic [BIT_W-1:0] bits_left;
        logic [WB_W-1:0]  wbits;
        logic [W-1:0]     sreg;
        logic [W-2:0]     rreg;
        logic             pol;
        logic             pha;
        logic [CS_W-1:0]  chan;
    } eng_st_t;

    eng_st_t st_d, st_q;
    logic [SH_W-1:0] low_bits;
    logic [WB_W-1:0] first_bits;

    assign low_bits   = len_i[SH_W-1:0] + 1'b1;
    assign first_bits = (low_bits == '0) ? WB_W'(W) : {1'b0, low_bits};

    always_comb begin
        st_d      = st_q;
        tx_pop_o  = 1'b0;
        rx_push_o = 1'b0;
        done_o    = 1'b0;
        rx_word_o = {st_q.rreg, miso_i};
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy      = 1'b1;
                st_d.half      = 1'b0;
                st_d.div       = '0;
                st_d.bits_left = {1'b0, len_i} + BIT_W'(1);
                st_d.wbits     = first_bits;
                st_d.sreg      = tx_word_i << (WB_W'(W) - first_bits);
                st_d.rreg      = '0;
                st_d.pol       = pol_i;
                st_d.pha       = pha_i;
                st_d.chan      = chan_i;
                tx_pop_o       = 1'b1;
            end
        end else if (st_q.div != DIV_END) begin
            st_d.div = st_q.div + 1'b1;
        end else begin
            st_d.div = '0;
            if (!st_q.half) begin
                st_d.half      = 1'b1;
                st_d.rreg      = rx_word_o[W-2:0];
                st_d.wbits     = st_q.wbits - 1'b1;
                st_d.bits_left = st_q.bits_left - 1'b1;
                rx_push_o      = (st_q.wbits == WB_W'(1));
            end else begin
                st_d.half = 1'b0;
                if (st_q.bits_left == '0) begin
                    st_d.busy = 1'b0;
                    done_o    = 1'b1;
                end else if (st_q.wbits == '0) begin
                    st_d.sreg  = tx_word_i;
                    st_d.wbits = WB_W'(W);
                    st_d.rreg  = '0;
                    tx_pop_o   = 1'b1;
                end else begin
                    st_d.sreg = st_q.sreg << 1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = st_q.busy;
    assign chan_o = st_q.chan;
    assign mosi_o = st_q.busy & st_q.sreg[W-1];
    assign sclk_o = st_q.busy ? (st_q.pol ^ st_q.pha ^ st_q.half) : rest_i;
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master #(
    parameter int unsigned FIFO_DEPTH = 8,
    parameter int unsigned HALF_DIV   = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        sclk_o,
    output logic        mosi_o,
    input  logic        miso_i,
    output logic [3:0]  ss_o
);
    import spi_burst_pkg::*;

    regs_t rg_d, rg_q;

    logic              wr_ctrl, wr_setup, wr_stat, go;
    logic [CS_W-1:0]   start_sel;
    logic              tx_pop, tx_empty, tx_full;
    logic [WORD_W-1:0] tx_head, tx_word;
    logic              rx_push, rx_pop, rx_empty, rx_full;
    logic [WORD_W-1:0] rx_head, rx_word;
    logic              eng_busy, eng_done;
    logic [CS_W-1:0]   act_chan;
    logic [NUM_CS-1:0] ssp_lv;
    logic              rest_sel, go_flag, done_flag, ovf_flag;

    assign wr_ctrl   = reg_wr && (reg_addr == ADDR_CTRL);
    assign wr_setup  = reg_wr && (reg_addr == ADDR_SETUP);
    assign wr_stat   = reg_wr && (reg_addr == ADDR_STAT);
    assign start_sel = reg_wdata[CTL_SEL_LO +: CS_W];
    assign go        = wr_ctrl && reg_wdata[CTL_ENABLE] && reg_wdata[CTL_MASTER]
                       && reg_wdata[CTL_GO] && !eng_busy;
    assign rx_pop    = reg_rd && (reg_addr == ADDR_RXQ) && !rx_empty;
    assign tx_word   = tx_empty ? '0 : tx_head;

    always_comb begin
        rg_d = rg_q;
        if (wr_ctrl) begin
            rg_d.enable = reg_wdata[CTL_ENABLE];
            rg_d.master = reg_wdata[CTL_MASTER];
            rg_d.sel    = start_sel;
            rg_d.len_m1 = reg_wdata[CTL_LEN_LO +: LEN_W];
        end
        if (go)            rg_d.go = 1'b1;
        else if (eng_done) rg_d.go = 1'b0;
        if (wr_setup) begin
            rg_d.pha     = reg_wdata[SET_PHA +: NUM_CS];
            rg_d.pol     = reg_wdata[SET_POL +: NUM_CS];
            rg_d.ssp     = reg_wdata[SET_SSP +: NUM_CS];
            rg_d.rst_lvl = reg_wdata[SET_RST +: NUM_CS];
        end
        if (wr_stat && reg_wdata[ST_DONE]) rg_d.done_flag = 1'b0;
        if (eng_done)                      rg_d.done_flag = 1'b1;
        if (wr_stat && reg_wdata[ST_OVF])  rg_d.ovf_flag = 1'b0;
        if (rx_push && rx_full)            rg_d.ovf_flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[CTL_ENABLE]             = rg_q.enable;
                reg_rdata[CTL_MASTER]             = rg_q.master;
                reg_rdata[CTL_GO]                 = rg_q.go;
                reg_rdata[CTL_SEL_LO +: CS_W]     = rg_q.sel;
                reg_rdata[CTL_LEN_LO +: LEN_W]    = rg_q.len_m1;
            end
            ADDR_SETUP: begin
                reg_rdata[SET_PHA +: NUM_CS] = rg_q.pha;
                reg_rdata[SET_POL +: NUM_CS] = rg_q.pol;
                reg_rdata[SET_SSP +: NUM_CS] = rg_q.ssp;
                reg_rdata[SET_RST +: NUM_CS] = rg_q.rst_lvl;
            end
            ADDR_STAT: begin
                reg_rdata[ST_DONE] = rg_q.done_flag;
                reg_rdata[ST_OVF]  = rg_q.ovf_flag;
            end
            ADDR_RXQ: reg_rdata = rx_empty ? '0 : rx_head;
            default:  reg_rdata = '0;
        endcase
    end

    spi_word_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(reg_wr && (reg_addr == ADDR_TXQ)), .push_data(reg_wdata),
        .pop(tx_pop), .head(tx_head), .empty(tx_empty), .full(tx_full)
    );

    spi_word_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .push_data(rx_word),
        .pop(rx_pop), .head(rx_head), .empty(rx_empty), .full(rx_full)
    );

    spi_shift_engine #(
        .W(WORD_W), .LEN_W(LEN_W), .CS_W(CS_W), .HALF_DIV(HALF_DIV)
    ) u_eng (
        .clk(clk), .rst_n(rst_n),
        .start_i(go),
        .len_i(reg_wdata[CTL_LEN_LO +: LEN_W]),
        .chan_i(start_sel),
        .pol_i(rg_q.pol[start_sel]),
        .pha_i(rg_q.pha[start_sel]),
        .rest_i(rest_sel),
        .tx_word_i(tx_word),
        .tx_pop_o(tx_pop),
        .rx_push_o(rx_push),
        .rx_word_o(rx_word),
        .busy_o(eng_busy),
        .done_o(eng_done),
        .chan_o(act_chan),
        .sclk_o(sclk_o),
        .mosi_o(mosi_o),
        .miso_i(miso_i)
    );

    assign ssp_lv    = rg_q.ssp;
    assign rest_sel  = rg_q.rst_lvl[rg_q.sel];
    assign go_flag   = rg_q.go;
    assign done_flag = rg_q.done_flag;
    assign ovf_flag  = rg_q.ovf_flag;

    for (genvar i = 0; i < NUM_CS; i++) begin : g_sel
        assign ss_o[i] = (eng_busy && (act_chan == CS_W'(i))) ? ssp_lv[i] : ~ssp_lv[i];
    end
endmodule

// File: rtl/spi_burst_master_checks.sv
module spi_burst_master_checks (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic [2:0] reg_addr,
    input logic [2:0] wlow,
    input logic       sclk_o,
    input logic [3:0] ss_o,
    input logic       eng_busy,
    input logic       eng_done,
    input logic [3:0] ssp_lv,
    input logic       rest_sel,
    input logic       go_flag,
    input logic       done_flag,
    input logic       ovf_flag,
    input logic       rx_push,
    input logic       rx_full
);
    a_r2_start_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_busy) |-> $past(reg_wr && reg_addr == 3'd0 && wlow == 3'b111));

    a_r7_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy |-> $countones(ss_o ^ ~ssp_lv) == 1);

    a_r7_all_released: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_busy |-> (ss_o == ~ssp_lv));

    a_r6_rest_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!eng_busy && $past(!eng_busy) && $stable(rest_sel)) |-> $stable(sclk_o));

    a_r8_done_flag: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> (done_flag && !go_flag && !eng_busy));

    a_r9_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full) |=> ovf_flag);
endmodule

bind spi_burst_master spi_burst_master_checks u_checks (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .wlow(reg_wdata[2:0]), .sclk_o(sclk_o), .ss_o(ss_o),
    .eng_busy(eng_busy), .eng_done(eng_done), .ssp_lv(ssp_lv),
    .rest_sel(rest_sel), .go_flag(go_flag), .done_flag(done_flag),
    .ovf_flag(ovf_flag), .rx_push(rx_push), .rx_full(rx_full)
);

// File: tb/spi_burst_master_test.sv
`timescale 1ns/1ps
module spi_burst_master_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sclk_o, mosi_o, miso = 1'b0;
    logic [3:0]  ss_o;

    spi_burst_master uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_i(miso), .ss_o(ss_o)
    );

    always #2 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit exp_mosi[$];
    bit miso_src[$];
    logic [31:0] exp_rx[$];
    int mon_err = 0, mon_extra = 0;
    logic mon_en = 1'b0, cur_pol = 1'b0, cur_pha = 1'b0;
    logic [31:0] setup_w = '0;
    logic [31:0] tx_buf [0:15];
    logic [31:0] sl_buf [0:15];

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic set_chan(input int ch, input bit pha, input bit pol, input bit ssp, input bit rst);
        setup_w[ch] = pha; setup_w[4+ch] = pol; setup_w[12+ch] = ssp; setup_w[20+ch] = rst;
        wr(3'd1, setup_w);
    endtask

    function automatic logic [3:0] idle_ss();
        return ~setup_w[15:12];
    endfunction

    // Monitor: slave model, pops expected MOSI bits at each sampling edge
    always @(sclk_o) begin
        if (mon_en && (sclk_o == ~(cur_pol ^ cur_pha))) begin
            if (exp_mosi.size() == 0) mon_extra++;
            else if (exp_mosi.pop_front() != mosi_o) mon_err++;
            if (miso_src.size() > 0) void'(miso_src.pop_front());
            miso = (miso_src.size() > 0) ? miso_src[0] : 1'b0;
        end
    end

    // Driver: fills queues, runs one burst, then drains and compares
    task automatic run_burst(input int ch, input int nbits, input int ntx, input int nsl);
        int nw, k, polls;
        logic [31:0] v, act_ss, word, sw;
        logic [3:0] exp_ss;
        nw = (nbits + 31) / 32;
        k = (nbits % 32 == 0) ? 32 : nbits % 32;
        cur_pha = setup_w[ch]; cur_pol = setup_w[4+ch];
        mon_err = 0; mon_extra = 0;
        for (int w = 0; w < nw; w++) begin
            int bits;
            bits = (w == 0) ? k : 32;
            word = (w < ntx) ? tx_buf[w] : 32'h0;
            sw   = (w < nsl) ? sl_buf[w] : 32'h0;
            for (int b = bits - 1; b >= 0; b--) begin
                exp_mosi.push_back(word[b]);
                miso_src.push_back(sw[b]);
            end
            if (w < 8) exp_rx.push_back((bits == 32) ? sw : (sw & ((32'h1 << bits) - 1)));
        end
        for (int w = 0; w < ntx; w++) wr(3'd3, tx_buf[w]);
        miso = miso_src[0];
        mon_en = 1'b1;
        wr(3'd0, (32'(nbits - 1) << 20) | (32'(ch) << 18) | 32'h7);
        @(negedge clk); @(negedge clk);
        exp_ss = idle_ss();
        exp_ss[ch] = setup_w[12+ch];
        act_ss = {28'h0, ss_o};
        check(ss_o == exp_ss, "R7 select held during burst", act_ss, {28'h0, exp_ss});
        polls = 0;
        v = '0;
        while (!v[7] && polls < 20000) begin
            rd(3'd2, v);
            polls++;
        end
        mon_en = 1'b0;
        check(v[7], "R8 done flag set", v, 32'h80);
        check(mon_extra == 0 && exp_mosi.size() == 0, "R3 sampling edge count",
              32'(mon_extra - exp_mosi.size()), 32'h0);
        check(mon_err == 0, "R4 MOSI bit order", 32'(mon_err), 32'h0);
        check(sclk_o == setup_w[20+ch], "R6 clock rest level after burst",
              {31'h0, sclk_o}, {31'h0, setup_w[20+ch]});
        check(ss_o == idle_ss(), "R7 selects released", {28'h0, ss_o}, {28'h0, idle_ss()});
        rd(3'd0, v);
        check(v[2] == 1'b0, "R8 go bit self-clears", v, v & ~32'h4);
        while (exp_rx.size() > 0) begin
            logic [31:0] e;
            e = exp_rx.pop_front();
            rd(3'd4, v);
            check(v == e, "R5 received word", v, e);
        end
        wr(3'd2, 32'h80);
        rd(3'd2, v);
        check(v[7] == 1'b0, "R8 done cleared by write-1", v, v & ~32'h80);
        miso_src.delete();
        exp_mosi.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic s0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(ss_o == 4'hF, "R1 selects inactive", {28'h0, ss_o}, 32'hF);
        check(sclk_o == 1'b0, "R1 clock low", {31'h0, sclk_o}, 32'h0);
        rd(3'd0, v); check(v == 0, "R1 control reset", v, 0);
        rd(3'd1, v); check(v == 0, "R1 setup reset", v, 0);
        rd(3'd2, v); check(v == 0, "R1 status reset", v, 0);

        // R2: go without enable, go without master
        s0 = sclk_o;
        wr(3'd0, 32'h0070_0004);
        repeat (40) @(negedge clk);
        check(sclk_o == s0, "R2 no clock without enable", {31'h0, sclk_o}, {31'h0, s0});
        rd(3'd2, v); check(v[7] == 0, "R2 no done without enable", v, 0);
        wr(3'd0, 32'h0070_0005);
        repeat (40) @(negedge clk);
        rd(3'd0, v); check(v[2] == 0, "R2 go not set without master", v, v & ~32'h4);
        rd(3'd2, v); check(v[7] == 0, "R2 no done without master", v, 0);

        // Burst 1: channel 0, mode 0, 8 bits
        set_chan(0, 0, 0, 0, 0);
        tx_buf[0] = 32'h0000_00A5; sl_buf[0] = 32'hFFFF_FF3C;
        run_burst(0, 8, 1, 1);

        // Burst 2: channel 1, phase 1, polarity 1, rest high, 40 bits
        set_chan(1, 1, 1, 0, 1);
        tx_buf[0] = 32'h1234_56C3; tx_buf[1] = 32'hDEAD_BEEF;
        sl_buf[0] = 32'h0000_0096; sl_buf[1] = 32'h0F1E_2D3C;
        run_burst(1, 40, 2, 2);

        // Burst 3: channel 2, phase 1, polarity 0, exactly one word
        set_chan(2, 1, 0, 0, 0);
        tx_buf[0] = 32'h8001_7FFE; sl_buf[0] = 32'hC0FF_EE11;
        run_burst(2, 32, 1, 1);

        // Burst 4: channel 3, active-high select, polarity 1, phase 0, 100 bits
        set_chan(3, 0, 1, 1, 1);
        check(ss_o == idle_ss(), "R7 active-high select idles low", {28'h0, ss_o}, {28'h0, idle_ss()});
        tx_buf[0] = 32'hFFFF_FFF9; tx_buf[1] = 32'h0123_4567;
        tx_buf[2] = 32'h89AB_CDEF; tx_buf[3] = 32'h5A5A_A5A5;
        sl_buf[0] = 32'h0000_0006; sl_buf[1] = 32'hFEDC_BA98;
        sl_buf[2] = 32'h7654_3210; sl_buf[3] = 32'h3333_CCCC;
        run_burst(3, 100, 4, 4);

        // R6: rest level differs from polarity on channel 0
        set_chan(0, 0, 0, 0, 1);
        wr(3'd0, 32'h0000_0003);
        @(negedge clk);
        check(sclk_o == 1'b1, "R6 rest level follows channel setting", {31'h0, sclk_o}, 32'h1);
        tx_buf[0] = 32'h0000_6B2D; sl_buf[0] = 32'h0000_4ACE;
        run_burst(0, 16, 1, 1);

        // R10: empty transmit queue sends zeros
        tx_buf[0] = 32'h0; sl_buf[0] = 32'h0000_ABCD;
        run_burst(0, 16, 0, 1);

        // R9: nine receive words into an eight-word queue
        set_chan(2, 0, 0, 0, 0);
        for (int i = 0; i < 8; i++) tx_buf[i] = 32'h1111_1111 * (i + 1);
        for (int i = 0; i < 9; i++) sl_buf[i] = 32'hA000_0000 + 32'(i * 7);
        run_burst(2, 288, 8, 9);
        rd(3'd2, v); check(v[6] == 1'b1, "R9 overflow flag set", v, 32'h40);
        rd(3'd4, v); check(v == 0, "R5 empty receive queue reads 0", v, 0);
        wr(3'd2, 32'h40);
        rd(3'd2, v); check(v == 0, "R9 overflow cleared by write-1", v, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule